// File: doc/BRIEF.md
# Tuner Control-Port Serial Slave

This block is the two-wire serial slave that sits at the control port of a tuner front end. It watches the oversampled clock and data lines of the bus and answers only to the fixed 7-bit device address 1100000. The line samples arrive from the system clock domain, and the block pulls the data line low through an open-drain enable. A write transaction carries a register pointer first, then any number of data bytes. Each data byte appears for one cycle on a parallel write port, and the pointer then moves on by one.

A read transaction takes no notice of the pointer. It always returns two status bytes. The first holds the charge-pump setting, a power-cycle flag and two VCO autoselect flags. The second holds the selected VCO, the selected sub-band and the 3-bit tuning-voltage ADC code. The status inputs are captured into a shadow copy at the moment the read address is acknowledged, so the two bytes always describe the same instant. The power-cycle flag is owned by the block. It is set by reset and is cleared by the STOP that closes a read.

Top module: `i2c_status_slave`

## Requirements
- R1: After a START, an address byte whose upper seven bits equal 1100000 is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the slave then stays silent and writes nothing until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START issued during a transaction (a repeated START) restarts address reception, and the new direction bit takes effect.
- R3: Bytes move most significant bit first. Each is followed by an acknowledge on the ninth clock. SDA is released (sda_oe = 0) after reset and whenever the slave is neither acknowledging nor sending a 0 data bit.
- R4: In a write (address bit 0 = 0), the first byte after the address loads the register pointer. Each later byte gives one single-cycle wr_en pulse with wr_addr = pointer and wr_data = byte, and the pointer then increments. Every such byte is acknowledged.
- R5: A data byte whose pointer is at or above NUM_REGS is still acknowledged, but it produces no wr_en pulse. The pointer still increments.
- R6: A write that carries only the address and the pointer before STOP produces no wr_en pulse.
- R7: In a read (address bit 0 = 1), the slave sends status byte 1 and then status byte 2, whatever value the pointer holds. Byte 1 = {3'b000, cp_set[1:0], power-cycle flag, vas_ok, vas_idle}.
- R8: Status byte 2 = {vco_sel[1:0], vsb_sel[2:0], vt_adc[2:0]}.
- R9: The power-cycle flag reads 1 after reset and stays 1 across write transactions. The STOP that ends a read transaction clears it to 0.
- R10: The status fields returned in a read are the values present when the read address byte was acknowledged. Later changes on the status inputs do not alter that read.
- R11: If the master does not acknowledge status byte 1, the slave sends nothing more and keeps SDA released until the next START.
- R12: The slave changes sda_oe only while SCL is low, never during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | 1 = pull SDA low (open drain) |
| cp_set | input | 2 | Charge-pump current setting |
| vas_ok | input | 1 | VCO autoselect succeeded |
| vas_idle | input | 1 | VCO autoselect is inactive |
| vco_sel | input | 2 | Selected VCO |
| vsb_sel | input | 3 | Selected VCO sub-band |
| vt_adc | input | 3 | Tuning-voltage ADC code |
| wr_en | output | 1 | Register write strobe, one cycle |
| wr_addr | output | $clog2(NUM_REGS) | Register index for the write |
| wr_data | output | 8 | Byte to write |

## Verification
If the bit counter or the state register is corrupted, it shows up on SDA within one byte. The acknowledge arrives on the wrong clock or never arrives, or read data comes out shifted by a bit. A master that checks each acknowledge and each read byte sees this in the same transaction. A wrong pointer shows up one byte later as a wr_addr that does not match, or as a missing or extra strobe. A wrong power-cycle flag or a wrong shadow copy is hidden until the next read, where it shows up in bit 2 of byte 1 or as status values that do not match the inputs at address time.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [6:0] DEV_ADDR = 7'b1100000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } link_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_phase_t;

    typedef struct packed {
        logic [1:0] cp;
        logic       pwr;
        logic       vas_ok;
        logic       vas_idle;
        logic [1:0] vco;
        logic [2:0] vsb;
        logic [2:0] adc;
    } tuner_stat_t;

    function automatic logic [7:0] stat_byte1(input tuner_stat_t s);
        return {3'b000, s.cp, s.pwr, s.vas_ok, s.vas_idle};
    endfunction

    function automatic logic [7:0] stat_byte2(input tuner_stat_t s);
        return {s.vco, s.vsb, s.adc};
    endfunction

endpackage

// File: rtl/i2cs_deglitch.sv
module i2cs_deglitch #(
    parameter int W    = 2,
    parameter int SYNC = 2,
    parameter int FILT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CW = (FILT > 1) ? $clog2(FILT + 1) : 1;

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [SYNC-1:0] sync_q;
        logic [CW-1:0]   cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q  <= '1;
                cnt_q   <= '0;
                dout[i] <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC-2:0], din[i]};
                if (sync_q[SYNC-1] == dout[i]) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(FILT - 1)) begin
                    cnt_q   <= '0;
                    dout[i] <= sync_q[SYNC-1];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
    import i2cs_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int AW       = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_f,
    input  logic          sda_f,
    input  tuner_stat_t   stat_i,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          rd_stop
);
    logic        scl_d, sda_d;
    logic        scl_rise, scl_fall, bus_start, bus_stop;
    link_state_t st;
    rx_phase_t   ph;
    logic [3:0]  bit_cnt;
    logic [7:0]  sh, tx_sh, ptr;
    logic        rd_mode, go_tx, byte_sel, m_ack;
    tuner_stat_t shadow;
    logic [7:0]  b2;

    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign bus_start = scl_f & scl_d & sda_d & ~sda_f;
    assign bus_stop  = scl_f & scl_d & ~sda_d & sda_f;
    assign b2        = stat_byte2(shadow);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
            st       <= ST_IDLE;
            ph       <= PH_ADDR;
            bit_cnt  <= '0;
            sh       <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_stop  <= 1'b0;
            rd_mode  <= 1'b0;
            go_tx    <= 1'b0;
            byte_sel <= 1'b0;
            m_ack    <= 1'b0;
            shadow   <= '0;
        end else begin
            scl_d   <= scl_f;
            sda_d   <= sda_f;
            wr_en   <= 1'b0;
            rd_stop <= 1'b0;
            if (bus_start) begin
                st      <= ST_RX;
                ph      <= PH_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                rd_mode <= 1'b0;
            end else if (bus_stop) begin
                st      <= ST_IDLE;
                sda_oe  <= 1'b0;
                rd_stop <= rd_mode;
                rd_mode <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            sh      <= {sh[6:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            go_tx   <= 1'b0;
                            unique case (ph)
                                PH_ADDR: begin
                                    if (sh[7:1] == DEV_ADDR) begin
                                        sda_oe <= 1'b1;
                                        st     <= ST_RX_ACK;
                                        ph     <= PH_PTR;
                                        go_tx  <= sh[0];
                                        if (sh[0]) begin
                                            shadow  <= stat_i;
                                            rd_mode <= 1'b1;
                                        end
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                PH_PTR: begin
                                    ptr    <= sh;
                                    ph     <= PH_DATA;
                                    sda_oe <= 1'b1;
                                    st     <= ST_RX_ACK;
                                end
                                default: begin
                                    if (int'(ptr) < NUM_REGS) begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr[AW-1:0];
                                        wr_data <= sh;
                                    end
                                    ptr    <= ptr + 1'b1;
                                    sda_oe <= 1'b1;
                                    st     <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            if (go_tx) begin
                                st       <= ST_TX;
                                byte_sel <= 1'b0;
                                tx_sh    <= stat_byte1(shadow);
                                sda_oe   <= ~stat_byte1(shadow)[7];
                            end else begin
                                st     <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                st      <= ST_TX_ACK;
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                sda_oe  <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_f;
                        end else if (scl_fall) begin
                            if (m_ack && !byte_sel) begin
                                byte_sel <= 1'b1;
                                st       <= ST_TX;
                                tx_sh    <= b2;
                                sda_oe   <= ~b2[7];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
    import i2cs_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int SYNC_LEN  = 2,
    parameter int FILT_LEN  = 3,
    localparam int AW       = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [1:0]    cp_set,
    input  logic          vas_ok,
    input  logic          vas_idle,
    input  logic [1:0]    vco_sel,
    input  logic [2:0]    vsb_sel,
    input  logic [2:0]    vt_adc,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    logic [1:0]  lines_f;
    logic        scl_f, sda_f;
    logic        pwr_q, rd_stop;
    tuner_stat_t stat;

    i2cs_deglitch #(.W(2), .SYNC(SYNC_LEN), .FILT(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .din  ({sda_i, scl_i}),
        .dout (lines_f)
    );

    assign scl_f = lines_f[0];
    assign sda_f = lines_f[1];

    always_comb begin
        stat.cp       = cp_set;
        stat.pwr      = pwr_q;
        stat.vas_ok   = vas_ok;
        stat.vas_idle = vas_idle;
        stat.vco      = vco_sel;
        stat.vsb      = vsb_sel;
        stat.adc      = vt_adc;
    end

    always_ff @(posedge clk) begin
        if (rst)          pwr_q <= 1'b1;
        else if (rd_stop) pwr_q <= 1'b0;
    end

    i2cs_link #(.NUM_REGS(NUM_REGS), .AW(AW)) u_link (
        .clk     (clk),
        .rst     (rst),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .stat_i  (stat),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_stop (rd_stop)
    );

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
    parameter int NUM_REGS = 8,
    parameter int AW       = $clog2(NUM_REGS)
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_f,
    input logic          sda_oe,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          pwr_q,
    input logic          rd_stop
);
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < NUM_REGS)); // R5

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R4

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe)); // R12

    AST_PWR_SET_BY_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pwr_q); // R9

    AST_PWR_CLEAR_ON_READ_STOP: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_q) |-> $past(rd_stop)); // R9

    AST_RELEASED_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        rd_stop |-> !sda_oe); // R3

endmodule

bind i2c_status_slave i2cs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_f),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .pwr_q   (pwr_q),
    .rd_stop (rd_stop)
);

// File: tb/i2c_status_slave_tb.sv
module i2c_status_slave_tb;
    localparam int NUM_REGS = 8;
    localparam int Q        = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe, wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] cp_set = 2'b10;
    logic       vas_ok = 1'b1, vas_idle = 1'b0;
    logic [1:0] vco_sel = 2'b01;
    logic [2:0] vsb_sel = 3'b101, vt_adc = 3'b011;
    wire        sda_bus = sda_m & ~sda_oe;

    int tests = 0, fails = 0, n_wr = 0, hi_moves = 0;
    logic [2:0] log_a [16];
    logic [7:0] log_d [16];
    logic       scl_p = 1'b1, oe_p = 1'b0;
    bit         done = 0;

    always #10 clk = ~clk;

    i2c_status_slave #(.NUM_REGS(NUM_REGS)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .cp_set(cp_set), .vas_ok(vas_ok), .vas_idle(vas_idle), .vco_sel(vco_sel),
        .vsb_sel(vsb_sel), .vt_adc(vt_adc), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en && n_wr < 16) begin
                log_a[n_wr] = wr_addr;
                log_d[n_wr] = wr_data;
            end
            if (wr_en) n_wr++;
            if (scl_m && scl_p && sda_oe != oe_p) hi_moves++;
        end
        scl_p = scl_m;
        oe_p  = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(posedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic m_bit(input logic b, output logic got);
        sda_m = b; wq(); scl_m = 1'b1; wq(); @(negedge clk); got = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_wr(input logic [7:0] b, output logic ack);
        logic g;
        for (int i = 7; i >= 0; i--) m_bit(b[i], g);
        m_bit(1'b1, g);
        ack = ~g;
    endtask

    task automatic m_rd(input logic give_ack, output logic [7:0] b);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, g);
            b[i] = g;
        end
        m_bit(~give_ack, g);
    endtask

    function automatic logic [7:0] exp_b1(input logic pwr);
        return {3'b000, cp_set, pwr, vas_ok, vas_idle};
    endfunction

    function automatic logic [7:0] exp_b2();
        return {vco_sel, vsb_sel, vt_adc};
    endfunction

    task automatic t_reset();
        chk("R3 sda released after reset", sda_oe, 0);
        chk("R4 no strobe after reset", wr_en, 0);
    endtask

    task automatic t_write_burst();
        logic a;
        int base = n_wr;
        m_start();
        m_wr(8'hC0, a); chk("R1 address ack", a, 1);
        m_wr(8'h00, a); chk("R4 pointer ack", a, 1);
        m_wr(8'h0E, a); chk("R3 data ack", a, 1);
        m_wr(8'hD8, a);
        m_wr(8'hE1, a); chk("R4 last data ack", a, 1);
        m_stop();
        chk("R4 strobe count", n_wr - base, 3);
        chk("R4 first addr", log_a[base], 0);
        chk("R4 first data", log_d[base], 8'h0E);
        chk("R4 second addr", log_a[base+1], 1);
        chk("R4 second data", log_d[base+1], 8'hD8);
        chk("R4 third addr", log_a[base+2], 2);
        chk("R4 third data", log_d[base+2], 8'hE1);
    endtask

    task automatic t_bad_addr();
        logic a;
        int base = n_wr;
        m_start();
        m_wr(8'h84, a); chk("R1 foreign address no ack", a, 0);
        m_wr(8'h01, a); chk("R1 ignored byte no ack", a, 0);
        m_wr(8'h55, a); chk("R1 ignored byte no ack", a, 0);
        m_stop();
        chk("R1 no writes when not addressed", n_wr - base, 0);
    endtask

    task automatic t_ptr_oob();
        logic a;
        int base = n_wr;
        m_start();
        m_wr(8'hC0, a);
        m_wr(8'h07, a);
        m_wr(8'hA5, a); chk("R5 in-range ack", a, 1);
        m_wr(8'h5A, a); chk("R5 out-of-range still acked", a, 1);
        m_stop();
        chk("R5 only one strobe", n_wr - base, 1);
        chk("R5 strobe addr", log_a[base], 7);
        chk("R5 strobe data", log_d[base], 8'hA5);
    endtask

    task automatic t_empty_write();
        logic a;
        int base = n_wr;
        m_start();
        m_wr(8'hC0, a);
        m_wr(8'h03, a); chk("R6 pointer ack", a, 1);
        m_stop();
        wq(2);
        chk("R6 no strobe", n_wr - base, 0);
    endtask

    task automatic t_read(input logic pwr_exp, input string tag);
        logic a;
        logic [7:0] b1, b2;
        m_start();
        m_wr(8'hC1, a); chk({tag, " read address ack"}, a, 1);
        m_rd(1'b1, b1);
        m_rd(1'b0, b2);
        m_stop();
        chk({tag, " status byte 1"}, b1, exp_b1(pwr_exp));
        chk("R8 status byte 2", b2, exp_b2());
    endtask

    task automatic t_shadow();
        logic a;
        logic [7:0] b1, b2, e1, e2;
        cp_set = 2'b01; vas_ok = 1'b0; vas_idle = 1'b1;
        vco_sel = 2'b10; vsb_sel = 3'b010; vt_adc = 3'b110;
        m_start();
        m_wr(8'hC1, a);
        e1 = exp_b1(1'b0);
        e2 = exp_b2();
        cp_set = 2'b11; vas_ok = 1'b1; vsb_sel = 3'b111; vt_adc = 3'b000;
        m_rd(1'b1, b1);
        m_rd(1'b1, b2);
        m_stop();
        chk("R10 byte 1 from capture", b1, e1);
        chk("R10 byte 2 from capture", b2, e2);
    endtask

    task automatic t_repeated_start();
        logic a;
        logic [7:0] b1, b2;
        int base = n_wr;
        m_start();
        m_wr(8'hC0, a);
        m_wr(8'h05, a);
        m_start();
        m_wr(8'hC1, a); chk("R2 repeated start read ack", a, 1);
        m_rd(1'b1, b1);
        m_rd(1'b0, b2);
        chk("R7 byte 1 regardless of pointer", b1, exp_b1(1'b0));
        chk("R8 byte 2 after repeated start", b2, exp_b2());
        m_start();
        m_wr(8'hC0, a); chk("R2 repeated start write ack", a, 1);
        m_wr(8'h02, a);
        m_wr(8'h3C, a);
        m_stop();
        chk("R2 one strobe after restart", n_wr - base, 1);
        chk("R2 strobe addr", log_a[base], 2);
        chk("R2 strobe data", log_d[base], 8'h3C);
    endtask

    task automatic t_nack_first();
        logic a;
        logic [7:0] b1, b2;
        m_start();
        m_wr(8'hC1, a);
        m_rd(1'b0, b1);
        chk("R7 byte 1 before nack", b1, exp_b1(1'b0));
        m_rd(1'b0, b2);
        chk("R11 bus released after nack", b2, 8'hFF);
        m_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        wq(2);
        t_write_burst();
        t_bad_addr();
        t_ptr_oob();
        t_empty_write();
        t_read(1'b1, "R9 flag set after reset and writes; R7");
        t_read(1'b0, "R9 flag cleared by read stop; R7");
        t_shadow();
        t_repeated_start();
        t_nack_first();
        chk("R12 no sda change during scl high", hi_moves, 0);
        finish_run();
    end

endmodule